// File: doc/BRIEF.md
# Context-Extended Translation Cache

This block is a small, fully associative cache of address translations. It sits between a CPU address port and an external table walker. Every incoming virtual address is first rewritten into a context-modified address. When the upper seven bits of the virtual address are all zero, those bits are replaced by the current 7-bit process identifier. Lookups and stored tags use only the modified address, so low-address processes map to distinct regions.

Each entry describes one mapping of 1 MB, 64 KB, 4 KB or 1 KB. A lookup compares only the page-number bits of each entry's own size. On a hit, one cycle after the request, the block returns the physical address, the stored domain and the permission field for the addressed subpage. On a miss it raises a walk request that stays up until the walker supplies a fill covering the missed address. That fill is stored in the round-robin victim slot and also answers the stalled lookup. The permission decision and the walk itself are done outside the block. A single-cycle pulse invalidates all entries.

Top module: `ctx_tlb`

## Requirements
- R1: After reset, rsp_valid_o and walk_req_o are low, and no entry is valid.
- R2: The modified address equals the virtual address when va[31:25] is non-zero. Otherwise it is the virtual address with bits [31:25] replaced by pid_i. It is visible on rsp_mva_o and walk_mva_o.
- R3: A request sampled at a clock edge with no walk outstanding raises rsp_valid_o for exactly the following cycle.
- R4: A missing request gives rsp_hit_o=0. In the same cycle walk_req_o rises with walk_mva_o equal to the modified address, and both hold until the miss completes.
- R5: A fill whose page (masked by its own size) contains the pending address completes the miss. The next cycle has rsp_valid_o=1, rsp_hit_o=1 and the filled translation, and walk_req_o drops.
- R6: Size codes are 0=1 MB, 1=64 KB, 2=4 KB and 3=1 KB. An entry matches when the page-number bits of its size agree. The physical address is the stored base with the modified address's in-page offset.
- R7: The permission word holds four 2-bit fields, with field n at bits [2n+1:2n]. rsp_ap_o returns field n, where n is mva[15:14] for 64 KB pages, mva[11:10] for 4 KB pages, and 0 for 1 MB and 1 KB pages. rsp_dom_o returns the stored domain.
- R8: Requests made while walk_req_o is high are ignored. They produce no response and leave walk_mva_o unchanged.
- R9: Fills occupy slots in rotation. Nine consecutive fills into an 8-entry block replace the first of them, and the other eight still hit.
- R10: A one-cycle inval_all_i pulse removes every entry. A fill in the same cycle is not stored.
- R11: A fill that does not cover the pending address is still stored. The miss stays outstanding and no response is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pid_i | input | 7 | Current process identifier |
| req_valid_i | input | 1 | Lookup request |
| req_va_i | input | 32 | Virtual address of the request |
| inval_all_i | input | 1 | Invalidate every entry |
| fill_valid_i | input | 1 | Walker fill strobe |
| fill_mva_i | input | 32 | Modified address covered by the fill |
| fill_size_i | input | 2 | Page size code of the fill |
| fill_pa_i | input | 32 | Physical base of the fill |
| fill_dom_i | input | 4 | Domain of the fill |
| fill_ap_i | input | 8 | Four permission fields of the fill |
| rsp_valid_o | output | 1 | Response strobe |
| rsp_hit_o | output | 1 | Translation found |
| rsp_mva_o | output | 32 | Modified address of the response |
| rsp_pa_o | output | 32 | Physical address |
| rsp_size_o | output | 2 | Page size code of the matching entry |
| rsp_dom_o | output | 4 | Domain of the matching entry |
| rsp_ap_o | output | 2 | Permission field for the addressed subpage |
| walk_req_o | output | 1 | Miss outstanding, walk requested |
| walk_mva_o | output | 32 | Modified address to walk |

## Verification
The bench probes addresses just inside and just outside each page size. A design that compared a fixed number of tag bits would either hit across a page boundary or miss inside a large page. It checks the subpage permission select for all four sizes, so a design that indexed sections or tiny pages by address bits would return the wrong field. It issues requests and unrelated fills while a walk is outstanding, which catches a design that answers stalled requests or treats any fill as completing the miss. It also checks that a context change turns a previous hit into a miss, and that a ninth fill evicts exactly the oldest entry.

// File: rtl/ctx_tlb_pkg.sv
`timescale 1ns/1ps
package ctx_tlb_pkg;
  localparam int ADDR_W = 32;
  localparam int PID_W  = 7;
  localparam int DOM_W  = 4;
  localparam int APF_W  = 2;
  localparam int APF_N  = 4;
  localparam int AP_W   = APF_W * APF_N;

  typedef enum logic [1:0] {
    PG_SECT  = 2'd0,
    PG_LARGE = 2'd1,
    PG_SMALL = 2'd2,
    PG_TINY  = 2'd3
  } pg_size_e;

  typedef struct packed {
    pg_size_e            size;
    logic [ADDR_W-1:0]   base;
    logic [DOM_W-1:0]    dom;
    logic [AP_W-1:0]     ap;
  } tlb_data_t;

  // in-page offset bits for each page size
  function automatic logic [ADDR_W-1:0] pg_off_mask(pg_size_e s);
    case (s)
      PG_SECT:  return ADDR_W'(32'h000F_FFFF);
      PG_LARGE: return ADDR_W'(32'h0000_FFFF);
      PG_SMALL: return ADDR_W'(32'h0000_0FFF);
      default:  return ADDR_W'(32'h0000_03FF);
    endcase
  endfunction

  // subpage permission field selection
  function automatic logic [APF_W-1:0] ap_pick(pg_size_e s, logic [ADDR_W-1:0] mva,
                                               logic [AP_W-1:0] ap);
    logic [1:0] idx;
    case (s)
      PG_LARGE: idx = mva[15:14];
      PG_SMALL: idx = mva[11:10];
      default:  idx = 2'd0;
    endcase
    return ap[idx*APF_W +: APF_W];
  endfunction
endpackage

// File: rtl/ctx_tlb_mva.sv
`timescale 1ns/1ps
module ctx_tlb_mva
  import ctx_tlb_pkg::*;
(
  input  logic [ADDR_W-1:0] va_i,
  input  logic [PID_W-1:0]  pid_i,
  output logic [ADDR_W-1:0] mva_o
);
  localparam int LOW_W = ADDR_W - PID_W;

  always_comb begin
    if (va_i[ADDR_W-1:LOW_W] == '0) mva_o = {pid_i, va_i[LOW_W-1:0]};
    else                            mva_o = va_i;
  end
endmodule

// File: rtl/ctx_tlb_slot.sv
`timescale 1ns/1ps
module ctx_tlb_slot
  import ctx_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inval_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_tag_i,
  input  tlb_data_t         wr_dat_i,
  input  logic [ADDR_W-1:0] mva_i,
  output logic              hit_o,
  output tlb_data_t         dat_o
);
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] tag_q;
  tlb_data_t         dat_q;

  always_comb begin
    vld_d = vld_q;
    if (wr_i)    vld_d = 1'b1;
    if (inval_i) vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_i && !inval_i) begin
      tag_q <= wr_tag_i;
      dat_q <= wr_dat_i;
    end
  end

  assign hit_o = vld_q && (((mva_i ^ tag_q) & ~pg_off_mask(dat_q.size)) == '0);
  assign dat_o = dat_q;
endmodule

// File: rtl/ctx_tlb_rr.sv
`timescale 1ns/1ps
module ctx_tlb_rr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (adv_i) ptr_d = (ptr_q == IDX_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/ctx_tlb.sv
`timescale 1ns/1ps
module ctx_tlb
  import ctx_tlb_pkg::*;
#(
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PID_W-1:0]  pid_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_va_i,
  input  logic              inval_all_i,
  input  logic              fill_valid_i,
  input  logic [ADDR_W-1:0] fill_mva_i,
  input  logic [1:0]        fill_size_i,
  input  logic [ADDR_W-1:0] fill_pa_i,
  input  logic [DOM_W-1:0]  fill_dom_i,
  input  logic [AP_W-1:0]   fill_ap_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [ADDR_W-1:0] rsp_mva_o,
  output logic [ADDR_W-1:0] rsp_pa_o,
  output logic [1:0]        rsp_size_o,
  output logic [DOM_W-1:0]  rsp_dom_o,
  output logic [APF_W-1:0]  rsp_ap_o,
  output logic              walk_req_o,
  output logic [ADDR_W-1:0] walk_mva_o
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ADDR_W-1:0] cur_mva;
  logic [IDX_W-1:0]  vic_ptr;
  logic [ENTRIES-1:0] slot_hit;
  tlb_data_t         slot_dat [ENTRIES];
  tlb_data_t         lk_dat, fill_dat;
  logic              lk_hit, accept, fill_match, store;
  pg_size_e          f_size;
  logic [ADDR_W-1:0] f_mask, lk_mask;

  logic              pend_q, pend_d;
  logic [ADDR_W-1:0] pend_mva_q, pend_mva_d;

  logic              rv_q, rv_d, rh_d, rh_q;
  logic [ADDR_W-1:0] rmva_d, rmva_q, rpa_d, rpa_q;
  logic [1:0]        rsz_d, rsz_q;
  logic [DOM_W-1:0]  rdom_d, rdom_q;
  logic [APF_W-1:0]  rap_d, rap_q;

  ctx_tlb_mva u_mva (.va_i(req_va_i), .pid_i(pid_i), .mva_o(cur_mva));

  assign f_size  = pg_size_e'(fill_size_i);
  assign f_mask  = pg_off_mask(f_size);
  assign store   = fill_valid_i && !inval_all_i;
  assign fill_dat = '{size: f_size, base: fill_pa_i & ~f_mask, dom: fill_dom_i, ap: fill_ap_i};

  ctx_tlb_rr #(.ENTRIES(ENTRIES)) u_rr (
    .clk(clk), .rst_n(rst_n), .adv_i(store), .ptr_o(vic_ptr)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    ctx_tlb_slot u_slot (
      .clk(clk), .rst_n(rst_n), .inval_i(inval_all_i),
      .wr_i(store && (vic_ptr == IDX_W'(g))),
      .wr_tag_i(fill_mva_i & ~f_mask), .wr_dat_i(fill_dat),
      .mva_i(cur_mva), .hit_o(slot_hit[g]), .dat_o(slot_dat[g])
    );
  end

  // lowest-numbered matching slot wins
  always_comb begin
    lk_dat = slot_dat[0];
    for (int i = ENTRIES-1; i >= 0; i--) begin
      if (slot_hit[i]) lk_dat = slot_dat[i];
    end
  end

  assign lk_hit     = |slot_hit;
  assign lk_mask    = pg_off_mask(lk_dat.size);
  assign accept     = req_valid_i && !pend_q;
  assign fill_match = fill_valid_i && pend_q && (((fill_mva_i ^ pend_mva_q) & ~f_mask) == '0);

  // miss tracking
  always_comb begin
    pend_d     = pend_q;
    pend_mva_d = pend_mva_q;
    if (accept && !lk_hit) begin
      pend_d     = 1'b1;
      pend_mva_d = cur_mva;
    end else if (fill_match) begin
      pend_d     = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk) begin
    if (accept && !lk_hit) pend_mva_q <= pend_mva_d;
  end

  // response next state
  always_comb begin
    rv_d   = accept || fill_match;
    rh_d   = lk_hit;
    rmva_d = cur_mva;
    rpa_d  = lk_dat.base | (cur_mva & lk_mask);
    rsz_d  = lk_dat.size;
    rdom_d = lk_dat.dom;
    rap_d  = ap_pick(lk_dat.size, cur_mva, lk_dat.ap);
    if (fill_match) begin
      rh_d   = 1'b1;
      rmva_d = pend_mva_q;
      rpa_d  = fill_dat.base | (pend_mva_q & f_mask);
      rsz_d  = fill_size_i;
      rdom_d = fill_dom_i;
      rap_d  = ap_pick(f_size, pend_mva_q, fill_ap_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rv_q <= 1'b0;
    else        rv_q <= rv_d;
  end

  always_ff @(posedge clk) begin
    if (rv_d) begin
      rh_q   <= rh_d;
      rmva_q <= rmva_d;
      rpa_q  <= rpa_d;
      rsz_q  <= rsz_d;
      rdom_q <= rdom_d;
      rap_q  <= rap_d;
    end
  end

  assign rsp_valid_o = rv_q;
  assign rsp_hit_o   = rh_q;
  assign rsp_mva_o   = rmva_q;
  assign rsp_pa_o    = rpa_q;
  assign rsp_size_o  = rsz_q;
  assign rsp_dom_o   = rdom_q;
  assign rsp_ap_o    = rap_q;
  assign walk_req_o  = pend_q;
  assign walk_mva_o  = pend_mva_q;
endmodule

// File: rtl/ctx_tlb_chk.sv
`timescale 1ns/1ps
module ctx_tlb_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid_i,
  input logic        inval_all_i,
  input logic        fill_valid_i,
  input logic        rsp_valid_o,
  input logic        rsp_hit_o,
  input logic [31:0] rsp_mva_o,
  input logic [31:0] rsp_pa_o,
  input logic        walk_req_o,
  input logic [31:0] walk_mva_o
);
  // R3
  rsp_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |-> ($past(req_valid_i && !walk_req_o) || $past(fill_valid_i && walk_req_o)));

  // R4
  walk_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_req_o) |-> (rsp_valid_o && !rsp_hit_o));

  // R8
  walk_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req_o && $past(walk_req_o)) |-> $stable(walk_mva_o));

  // R5
  walk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(walk_req_o) |-> (rsp_valid_o && rsp_hit_o));

  // R6
  offset_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_hit_o) |-> (rsp_pa_o[9:0] == rsp_mva_o[9:0]));

  // R10
  flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(inval_all_i) && req_valid_i && !walk_req_o) |=> (rsp_valid_o && !rsp_hit_o));
endmodule

bind ctx_tlb ctx_tlb_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i), .inval_all_i(inval_all_i),
  .fill_valid_i(fill_valid_i), .rsp_valid_o(rsp_valid_o), .rsp_hit_o(rsp_hit_o),
  .rsp_mva_o(rsp_mva_o), .rsp_pa_o(rsp_pa_o), .walk_req_o(walk_req_o),
  .walk_mva_o(walk_mva_o)
);

// File: tb/sim_ctx_tlb.sv
`timescale 1ns/1ps
module sim_ctx_tlb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  pid = 7'd5;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        inval = 1'b0;
  logic        fill_valid = 1'b0;
  logic [31:0] fill_mva = '0;
  logic [1:0]  fill_size = '0;
  logic [31:0] fill_pa = '0;
  logic [3:0]  fill_dom = '0;
  logic [7:0]  fill_ap = '0;
  logic        rsp_valid, rsp_hit, walk_req;
  logic [31:0] rsp_mva, rsp_pa, walk_mva;
  logic [1:0]  rsp_size, rsp_ap;
  logic [3:0]  rsp_dom;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ctx_tlb u0 (
    .clk(clk), .rst_n(rst_n), .pid_i(pid), .req_valid_i(req_valid), .req_va_i(req_va),
    .inval_all_i(inval), .fill_valid_i(fill_valid), .fill_mva_i(fill_mva),
    .fill_size_i(fill_size), .fill_pa_i(fill_pa), .fill_dom_i(fill_dom), .fill_ap_i(fill_ap),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_mva_o(rsp_mva), .rsp_pa_o(rsp_pa),
    .rsp_size_o(rsp_size), .rsp_dom_o(rsp_dom), .rsp_ap_o(rsp_ap),
    .walk_req_o(walk_req), .walk_mva_o(walk_mva)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic send_req(input logic [31:0] va);
    @(negedge clk);
    req_valid = 1'b1; req_va = va;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic send_fill(input logic [31:0] mva, input logic [1:0] sz, input logic [31:0] pa,
                           input logic [3:0] dom, input logic [7:0] ap);
    @(negedge clk);
    fill_valid = 1'b1; fill_mva = mva; fill_size = sz; fill_pa = pa; fill_dom = dom; fill_ap = ap;
    @(posedge clk); #1;
    fill_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    idle(1);
    check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R1 walk_req", 32'(walk_req), 32'd0);
  endtask

  task automatic t_small_page;
    send_req(32'h0012_3456);
    check("R3 rsp_valid", 32'(rsp_valid), 32'd1);
    check("R4 miss", 32'(rsp_hit), 32'd0);
    check("R2 pid substitution", rsp_mva, 32'h0A12_3456);
    check("R4 walk_req", 32'(walk_req), 32'd1);
    check("R4 walk_mva", walk_mva, 32'h0A12_3456);
    idle(1);
    check("R3 single pulse", 32'(rsp_valid), 32'd0);
    check("R4 walk held", 32'(walk_req), 32'd1);
    send_fill(32'h0A12_3000, 2'd2, 32'h8000_0000, 4'd3, 8'hE4);
    check("R5 completion valid", 32'(rsp_valid), 32'd1);
    check("R5 completion hit", 32'(rsp_hit), 32'd1);
    check("R5 completion pa", rsp_pa, 32'h8000_0456);
    check("R7 small ap field1", 32'(rsp_ap), 32'd1);
    check("R7 domain", 32'(rsp_dom), 32'd3);
    check("R5 walk dropped", 32'(walk_req), 32'd0);
    send_req(32'h0012_3FFC);
    check("R6 same 4K page hit", 32'(rsp_hit), 32'd1);
    check("R6 small pa", rsp_pa, 32'h8000_0FFC);
    check("R7 small ap field3", 32'(rsp_ap), 32'd3);
    check("R6 size code", 32'(rsp_size), 32'd2);
    send_req(32'h0012_4000);
    check("R6 next 4K page misses", 32'(rsp_hit), 32'd0);
    check("R4 walk_mva next page", walk_mva, 32'h0A12_4000);
  endtask

  task automatic t_large_page;
    send_fill(32'h0A12_0000, 2'd1, 32'h4000_0000, 4'd7, 8'h1B);
    check("R5 large completion hit", 32'(rsp_hit), 32'd1);
    check("R6 large pa", rsp_pa, 32'h4000_4000);
    check("R7 large ap field1", 32'(rsp_ap), 32'd2);
    check("R7 large domain", 32'(rsp_dom), 32'd7);
    send_req(32'h0012_FFFF);
    check("R6 large hit", 32'(rsp_hit), 32'd1);
    check("R6 large pa end", rsp_pa, 32'h4000_FFFF);
    check("R7 large ap field3", 32'(rsp_ap), 32'd0);
    pid = 7'd6;
    send_req(32'h0012_3456);
    check("R2 new context mva", rsp_mva, 32'h0C12_3456);
    check("R2 new context misses", 32'(rsp_hit), 32'd0);
    send_fill(32'h0C12_3000, 2'd2, 32'h8000_1000, 4'd1, 8'h00);
    check("R5 context completion", rsp_pa, 32'h8000_1456);
    pid = 7'd5;
  endtask

  task automatic t_section;
    send_req(32'h8030_0010);
    check("R2 pass-through", rsp_mva, 32'h8030_0010);
    check("R4 section miss", 32'(rsp_hit), 32'd0);
    send_fill(32'h8030_0000, 2'd0, 32'h1230_0000, 4'd9, 8'h02);
    check("R5 section pa", rsp_pa, 32'h1230_0010);
    check("R7 section ap", 32'(rsp_ap), 32'd2);
    send_req(32'h803F_FFF0);
    check("R6 section hit", 32'(rsp_hit), 32'd1);
    check("R6 section pa", rsp_pa, 32'h123F_FFF0);
    check("R7 section single field", 32'(rsp_ap), 32'd2);
    check("R7 section domain", 32'(rsp_dom), 32'd9);
  endtask

  task automatic t_tiny_and_stall;
    send_req(32'h9000_0400);
    check("R4 tiny miss", 32'(rsp_hit), 32'd0);
    send_fill(32'h9000_0400, 2'd3, 32'h0000_8C00, 4'd2, 8'hC0);
    check("R5 tiny pa", rsp_pa, 32'h0000_8C00);
    check("R7 tiny field0", 32'(rsp_ap), 32'd0);
    send_req(32'h9000_07FF);
    check("R6 tiny hit", 32'(rsp_hit), 32'd1);
    check("R6 tiny pa", rsp_pa, 32'h0000_8FFF);
    send_req(32'h9000_0800);
    check("R6 next tiny misses", 32'(rsp_hit), 32'd0);
    send_req(32'h803F_FFF0);
    check("R8 stalled request no response", 32'(rsp_valid), 32'd0);
    check("R8 walk_mva kept", walk_mva, 32'h9000_0800);
    send_fill(32'h7000_0000, 2'd0, 32'h0000_0000, 4'd0, 8'h00);
    check("R11 unrelated fill no response", 32'(rsp_valid), 32'd0);
    check("R11 walk still up", 32'(walk_req), 32'd1);
    send_fill(32'h9000_0800, 2'd3, 32'h0000_9000, 4'd2, 8'h00);
    check("R5 tiny completion", rsp_pa, 32'h0000_9000);
    send_req(32'h7001_2345);
    check("R11 unrelated fill stored", 32'(rsp_hit), 32'd1);
    check("R11 stored pa", rsp_pa, 32'h0001_2345);
  endtask

  task automatic t_invalidate;
    @(negedge clk);
    inval = 1'b1;
    fill_valid = 1'b1; fill_mva = 32'h6000_0000; fill_size = 2'd0; fill_pa = 32'h0; fill_dom = 4'd0; fill_ap = 8'h0;
    @(posedge clk); #1;
    inval = 1'b0; fill_valid = 1'b0;
    send_req(32'h803F_FFF0);
    check("R10 flushed entry misses", 32'(rsp_hit), 32'd0);
    send_fill(32'h8030_0000, 2'd0, 32'h1230_0000, 4'd9, 8'h02);
    check("R5 refill completes", 32'(rsp_hit), 32'd1);
    send_req(32'h7001_2345);
    check("R10 all entries flushed", 32'(rsp_hit), 32'd0);
    send_fill(32'h7000_0000, 2'd0, 32'h0000_0000, 4'd0, 8'h00);
    send_req(32'h6000_0004);
    check("R10 same-cycle fill dropped", 32'(rsp_hit), 32'd0);
    send_fill(32'h6000_0000, 2'd0, 32'h0500_0000, 4'd0, 8'h00);
    check("R5 completion after flush", rsp_pa, 32'h0500_0004);
  endtask

  task automatic t_round_robin;
    for (int k = 0; k < 9; k++) begin
      send_fill(32'hC000_0000 + (k << 20), 2'd0, 32'h2000_0000 + (k << 20), 4'd0, 8'h00);
    end
    send_req(32'hC010_0000);
    check("R9 second fill kept", 32'(rsp_hit), 32'd1);
    check("R9 second fill pa", rsp_pa, 32'h2010_0000);
    send_req(32'hC080_0000);
    check("R9 ninth fill present", rsp_pa, 32'h2080_0000);
    send_req(32'hC000_0000);
    check("R9 first fill evicted", 32'(rsp_hit), 32'd0);
    send_fill(32'hC000_0000, 2'd0, 32'h2000_0000, 4'd0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_small_page();
    t_large_page();
    t_section();
    t_tiny_and_stall();
    t_invalidate();
    t_round_robin();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule